// File: doc/BRIEF.md
# Page-buffered write-cycle controller for a byte-wide non-volatile memory

This block is the control core of a byte-wide parallel non-volatile memory. An external master drives active-low chip enable, output enable and write enable, an address and a byte of data, all sampled on the system clock. A write strobe latches the address when write enable falls and the data when it rises. The byte goes into a page register at the offset given by the low address bits. Further bytes may join the same page while a load window timer runs, and every accepted byte restarts that timer. When the window lapses, a self-timed program cycle starts and runs for a fixed number of clocks. At its end, every loaded byte is committed to the storage array in one step. Offsets that were not loaded keep their old contents.

While the program cycle is busy, reads do not return stored data. They return a status byte instead: bit 7 is the inverse of bit 7 of the last byte accepted, bit 6 flips on every new read access, and bits 5..0 are zero. When the cycle ends, reads return true array contents again. Write strobes that arrive during the busy cycle are dropped.

The data bus is split into an input, an output and a drive-enable output. The pad ring combines them into the bidirectional pins. The address width defaults to 11 bits to keep elaboration light; an ADDR_W of 16 gives the full 64K-byte map.

Top module: `eew_wr_ctrl`

## Requirements
- R1: After reset, data_oe is 0, no cycle is busy and every array location reads as 0x00.
- R2: data_oe is 1 exactly when ce_n=0, oe_n=0 and we_n=1. When data_oe is 0, data_out is 0x00. When no program cycle is busy, data_out equals the array byte at addr.
- R3: A byte is accepted on a rising edge of we_n while ce_n=0 and oe_n=1. The byte written is the data present at that rise, and its address is the one present at the preceding falling edge of we_n. The byte is placed at offset addr[PAGE_W-1:0] of the page register.
- R4: Each accepted byte restarts the load window. The program cycle begins LOAD_TO clock edges after the last accepted byte. Counting that byte's accepting edge as edge 0, reads show status from edge LOAD_TO onward.
- R5: The program cycle lasts WRITE_CYC clock edges. Counting as in R4, status is shown through edge LOAD_TO+WRITE_CYC-1, and from edge LOAD_TO+WRITE_CYC reads return the newly committed bytes.
- R6: While busy, a read at any address returns bit 7 equal to the inverse of bit 7 of the last accepted byte, and bits 5..0 equal to 0.
- R7: While busy, bit 6 of the status is 0 at the start of each program cycle. It inverts on the first clock edge of each new read access, so the k-th access started within a cycle shows k mod 2. After the cycle ends, reads of data are stable from one read to the next.
- R8: Page offsets not loaded during a load window keep their previous array contents when the page is committed.
- R9: Write strobes during a busy program cycle change neither the array nor the page register, and they start no later cycle.
- R10: The page of a load window is taken from addr[ADDR_W-1:PAGE_W] of its first byte. Later bytes in the same window use only their low address bits.
- R11: During the load window, before the program cycle starts, reads return the old array contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address; the upper ADDR_W-PAGE_W bits select the page |
| data_in | input | 8 | Write data from the bus |
| data_out | output | 8 | Read data or busy status |
| data_oe | output | 1 | Drive enable for the bidirectional data pins |

## Verification
The bench builds the block with ADDR_W=9, PAGE_W=4, LOAD_TO=20 and WRITE_CYC=40. That gives 32 pages of 16 bytes and short timers, so every location can be written through full pages and through half-loaded pages and then read back against an arithmetic pattern. The short timers also allow the busy window to be measured edge by edge around both of its boundaries. Within one busy cycle there is room for several status reads, for strobes that must be dropped, and for a second cycle that shows the toggle bit starting again from zero.

// File: rtl/eew_pkg.sv
package eew_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_PROG = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic wr_fall;
        logic wr_rise;
        logic rd_act;
        logic rd_start;
    } strobe_ev_t;

    function automatic logic [BYTE_W-1:0] busy_pattern(input logic last_msb, input logic tog);
        return {~last_msb, tog, {(BYTE_W-2){1'b0}}};
    endfunction

endpackage

// File: rtl/eew_strobe.sv
module eew_strobe
    import eew_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ce_n,
    input  logic       oe_n,
    input  logic       we_n,
    output strobe_ev_t ev
);
    logic we_q;
    logic rd_q;
    logic wr_sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            we_q <= 1'b1;
            rd_q <= 1'b0;
        end else begin
            we_q <= we_n;
            rd_q <= ev.rd_act;
        end
    end

    always_comb begin
        wr_sel      = !ce_n && oe_n;
        ev.wr_fall  = wr_sel && !we_n && we_q;
        ev.wr_rise  = wr_sel && we_n && !we_q;
        ev.rd_act   = !ce_n && !oe_n && we_n;
        ev.rd_start = ev.rd_act && !rd_q;
    end

endmodule

// File: rtl/eew_seq.sv
module eew_seq
    import eew_pkg::*;
#(
    parameter int LOAD_TO   = 300,
    parameter int WRITE_CYC = 2000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       accept,
    output seq_state_e state,
    output logic       commit
);
    localparam int LW = $clog2(LOAD_TO + 1);
    localparam int WW = $clog2(WRITE_CYC + 1);

    logic [LW-1:0] lcnt;
    logic [WW-1:0] wcnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            lcnt  <= '0;
            wcnt  <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        state <= ST_LOAD;
                        lcnt  <= '0;
                    end
                end
                ST_LOAD: begin
                    if (accept) begin
                        lcnt <= '0;
                    end else if (lcnt == LW'(LOAD_TO - 1)) begin
                        state <= ST_PROG;
                        wcnt  <= '0;
                    end else begin
                        lcnt <= lcnt + 1'b1;
                    end
                end
                ST_PROG: begin
                    if (wcnt == WW'(WRITE_CYC - 1)) begin
                        state <= ST_IDLE;
                    end else begin
                        wcnt <= wcnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign commit = (state == ST_PROG) && (wcnt == WW'(WRITE_CYC - 1));

    // R4: the load window counter never runs past its limit
    a_r4_load_bound: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LOAD) |-> (int'(lcnt) < LOAD_TO));

    // R4: a program cycle is only entered from an expired load window
    a_r4_prog_entry: assert property (@(posedge clk) disable iff (rst)
        $rose(state == ST_PROG) |-> ($past(state) == ST_LOAD && int'($past(lcnt)) == LOAD_TO - 1));

    // R5: a program cycle ends only after its full length
    a_r5_prog_len: assert property (@(posedge clk) disable iff (rst)
        $fell(state == ST_PROG) |-> (int'($past(wcnt)) == WRITE_CYC - 1));

endmodule

// File: rtl/eew_page_buf.sv
module eew_page_buf
    import eew_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int PAGE_W = 7
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               accept,
    input  logic                               first,
    input  logic                               busy,
    input  logic                               commit,
    input  logic [ADDR_W-1:0]                  acc_addr,
    input  logic [BYTE_W-1:0]                  acc_data,
    output logic [ADDR_W-PAGE_W-1:0]           page_q,
    output logic [(1<<PAGE_W)-1:0]             valid,
    output logic [(1<<PAGE_W)-1:0][BYTE_W-1:0] bytes
);
    localparam int PB = ADDR_W - PAGE_W;

    logic [PAGE_W-1:0] off;
    assign off = acc_addr[PAGE_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            page_q <= '0;
            valid  <= '0;
            bytes  <= '0;
        end else if (commit) begin
            valid <= '0;
        end else if (accept) begin
            if (first) begin
                page_q <= acc_addr[ADDR_W-1:PAGE_W];
            end
            bytes[off] <= acc_data;
            valid[off] <= 1'b1;
        end
    end

    // R9: the page register is frozen while a program cycle runs
    a_r9_buf_frozen: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> ($stable(valid) && $stable(bytes) && $stable(page_q)));

    // R10: the page of a window is fixed once its first byte is in
    a_r10_page_fixed: assert property (@(posedge clk) disable iff (rst)
        ($past(valid) != '0 && !$past(commit)) |-> $stable(page_q));

    localparam int UNUSED_PB = PB;

endmodule

// File: rtl/eew_array.sv
module eew_array
    import eew_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int PAGE_W = 7
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               commit,
    input  logic [ADDR_W-PAGE_W-1:0]           page_q,
    input  logic [(1<<PAGE_W)-1:0]             valid,
    input  logic [(1<<PAGE_W)-1:0][BYTE_W-1:0] bytes,
    input  logic [ADDR_W-1:0]                  rd_addr,
    output logic [BYTE_W-1:0]                  rd_data
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int PAGE  = 1 << PAGE_W;

    logic [BYTE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (commit) begin
            for (int j = 0; j < PAGE; j++) begin
                if (valid[j]) begin
                    mem[{page_q, PAGE_W'(j)}] <= bytes[j];
                end
            end
        end
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/eew_wr_ctrl.sv
module eew_wr_ctrl
    import eew_pkg::*;
#(
    parameter int ADDR_W    = 11,
    parameter int PAGE_W    = 7,
    parameter int LOAD_TO   = 300,
    parameter int WRITE_CYC = 2000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        data_in,
    output logic [7:0]        data_out,
    output logic              data_oe
);
    localparam int PB   = ADDR_W - PAGE_W;
    localparam int PAGE = 1 << PAGE_W;

    strobe_ev_t ev;
    seq_state_e state;
    logic       commit;
    logic       busy;
    logic       accept;
    logic       tog;
    logic       last_msb;

    logic [ADDR_W-1:0]            addr_lat;
    logic [PB-1:0]                page_q;
    logic [PAGE-1:0]              valid;
    logic [PAGE-1:0][BYTE_W-1:0]  bytes;
    logic [BYTE_W-1:0]            rd_data;

    eew_strobe u_strobe (
        .clk  (clk),
        .rst  (rst),
        .ce_n (ce_n),
        .oe_n (oe_n),
        .we_n (we_n),
        .ev   (ev)
    );

    assign busy   = (state == ST_PROG);
    assign accept = ev.wr_rise && !busy;

    eew_seq #(
        .LOAD_TO   (LOAD_TO),
        .WRITE_CYC (WRITE_CYC)
    ) u_seq (
        .clk    (clk),
        .rst    (rst),
        .accept (accept),
        .state  (state),
        .commit (commit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_lat <= '0;
            last_msb <= 1'b0;
        end else begin
            if (ev.wr_fall) begin
                addr_lat <= addr;
            end
            if (accept) begin
                last_msb <= data_in[7];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !busy) begin
            tog <= 1'b0;
        end else if (ev.rd_start) begin
            tog <= ~tog;
        end
    end

    eew_page_buf #(
        .ADDR_W (ADDR_W),
        .PAGE_W (PAGE_W)
    ) u_buf (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .first    (state == ST_IDLE),
        .busy     (busy),
        .commit   (commit),
        .acc_addr (addr_lat),
        .acc_data (data_in),
        .page_q   (page_q),
        .valid    (valid),
        .bytes    (bytes)
    );

    eew_array #(
        .ADDR_W (ADDR_W),
        .PAGE_W (PAGE_W)
    ) u_array (
        .clk     (clk),
        .rst     (rst),
        .commit  (commit),
        .page_q  (page_q),
        .valid   (valid),
        .bytes   (bytes),
        .rd_addr (addr),
        .rd_data (rd_data)
    );

    always_comb begin
        data_oe = ev.rd_act;
        if (!ev.rd_act) begin
            data_out = '0;
        end else if (busy) begin
            data_out = busy_pattern(last_msb, tog);
        end else begin
            data_out = rd_data;
        end
    end

    // R7: the toggle bit starts every program cycle at zero
    a_r7_tog_start: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !tog);

    // R7: the toggle bit moves only on a new read access
    a_r7_tog_hold: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && !$past(ev.rd_start)) |-> $stable(tog));

    // R6: the status inverts bit 7 of the last accepted byte
    a_r6_status_msb: assert property (@(posedge clk) disable iff (rst)
        (busy && ev.rd_act) |-> (data_out[7] != last_msb && data_out[5:0] == 6'd0));

    // R9: the last accepted byte is not replaced during a busy cycle
    a_r9_last_hold: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(last_msb));

endmodule

// File: tb/tb_eew_wr_ctrl.sv
module tb_eew_wr_ctrl;

    localparam int AW   = 9;
    localparam int PW   = 4;
    localparam int L    = 20;
    localparam int W    = 40;
    localparam int PG   = 1 << PW;
    localparam int NPG  = 1 << (AW - PW);
    localparam int DEP  = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ce_n = 1'b1;
    logic          oe_n = 1'b1;
    logic          we_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [7:0]    din  = '0;
    logic [7:0]    dout;
    logic          doe;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [7:0] exp_mem [DEP];

    always #2.5 clk = ~clk;

    eew_wr_ctrl #(
        .ADDR_W    (AW),
        .PAGE_W    (PW),
        .LOAD_TO   (L),
        .WRITE_CYC (W)
    ) dut (
        .clk      (clk),
        .rst      (rst),
        .ce_n     (ce_n),
        .oe_n     (oe_n),
        .we_n     (we_n),
        .addr     (addr),
        .data_in  (din),
        .data_out (dout),
        .data_oe  (doe)
    );

    function automatic logic [7:0] pat1(input int a);
        int t;
        t = a * 37 + 5 + (a >> 4);
        return t[7:0];
    endfunction

    function automatic logic [7:0] pat2(input int a);
        return ~pat1(a) ^ 8'h5a;
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        @(negedge clk);
        addr = AW'(a);
        din  = d;
        we_n = 1'b0;
        @(negedge clk);
        we_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic rd(input int a, output logic [7:0] v);
        @(negedge clk);
        addr = AW'(a);
        oe_n = 1'b0;
        @(negedge clk);
        v = dout;
        oe_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wait_done();
        repeat (L + W + 4) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        for (int i = 0; i < DEP; i++) exp_mem[i] = 8'h00;
        ce_n = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        chk("R1 data_oe idle", {7'd0, doe}, 8'h00);
        rd(5, v);   chk("R1 reset contents", v, 8'h00);
        rd(300, v); chk("R1 reset contents", v, 8'h00);

        // R2: drive enable decode
        @(negedge clk); ce_n = 1'b1; oe_n = 1'b0;
        @(negedge clk);
        chk("R2 no drive ce_n=1", {7'd0, doe}, 8'h00);
        chk("R2 quiet data_out", dout, 8'h00);
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b0;
        @(negedge clk);
        chk("R2 no drive we_n=0", {7'd0, doe}, 8'h00);
        we_n = 1'b1;
        @(negedge clk);
        chk("R2 drive on read", {7'd0, doe}, 8'h01);
        oe_n = 1'b1;
        @(negedge clk);

        // R3 R5: fill every page, then read back all locations
        for (int p = 0; p < NPG; p++) begin
            for (int o = 0; o < PG; o++) begin
                wr(p * PG + o, pat1(p * PG + o));
                exp_mem[p * PG + o] = pat1(p * PG + o);
            end
            wait_done();
        end
        for (int a = 0; a < DEP; a++) begin
            rd(a, v);
            chk("R3 R5 full page sweep", v, exp_mem[a]);
        end

        // R8: half-loaded pages keep the unloaded offsets
        for (int p = 0; p < NPG; p++) begin
            for (int o = 0; o < PG; o += 2) begin
                wr(p * PG + o, pat2(p * PG + o));
                exp_mem[p * PG + o] = pat2(p * PG + o);
            end
            wait_done();
        end
        for (int a = 0; a < DEP; a++) begin
            rd(a, v);
            chk("R8 partial page sweep", v, exp_mem[a]);
        end

        // R10: the page comes from the first byte of the window
        wr(3 * PG + 2, 8'hc3);
        wr(5 * PG + 7, 8'h3c);
        exp_mem[3 * PG + 2] = 8'hc3;
        exp_mem[3 * PG + 7] = 8'h3c;
        wait_done();
        rd(3 * PG + 7, v); chk("R10 second byte lands in first page", v, 8'h3c);
        rd(5 * PG + 7, v); chk("R10 other page untouched", v, exp_mem[5 * PG + 7]);
        rd(3 * PG + 2, v); chk("R10 first byte", v, 8'hc3);

        // R4 R5 R11: window restart and busy window edges
        wr(96, 8'h77);
        exp_mem[96] = 8'h77;
        repeat (L - 5) @(negedge clk);
        @(negedge clk);
        addr = AW'(100); din = 8'h12; we_n = 1'b0;
        @(negedge clk);
        we_n = 1'b1;
        for (int n = 0; n <= L + W; n++) begin
            @(negedge clk);
            if (n == 0) oe_n = 1'b0;
            if (n == L - 1)     chk("R11 R4 old data before start", dout, exp_mem[100]);
            if (n == L)         chk("R4 status at window end", dout, 8'h80);
            if (n == L + W - 1) chk("R5 status at last busy edge", dout, 8'h80);
            if (n == L + W)     chk("R5 new data after cycle", dout, 8'h12);
        end
        oe_n = 1'b1;
        exp_mem[100] = 8'h12;
        rd(96, v); chk("R4 restarted window byte", v, 8'h77);

        // R6 R7: status bits over successive reads
        wr(200, 8'h5a);
        repeat (L + 3) @(negedge clk);
        rd(200, v); chk("R7 first read toggle", v, 8'hc0);
        rd(200, v); chk("R7 second read toggle", v, 8'h80);
        rd(7, v);   chk("R6 status at any address", v, 8'hc0);
        wait_done();
        exp_mem[200] = 8'h5a;
        rd(200, v); chk("R7 stable after cycle", v, 8'h5a);
        rd(200, v); chk("R7 stable after cycle", v, 8'h5a);
        wr(201, 8'ha5);
        repeat (L + 3) @(negedge clk);
        rd(201, v); chk("R7 toggle restarts at zero", v, 8'h40);
        rd(3, v);   chk("R6 status inverse msb", v, 8'h00);
        wait_done();
        exp_mem[201] = 8'ha5;

        // R9: strobes during a busy cycle are dropped
        wr(300, 8'h11);
        repeat (L + 3) @(negedge clk);
        wr(301, 8'h22);
        wait_done();
        wait_done();
        exp_mem[300] = 8'h11;
        rd(301, v); chk("R9 busy strobe ignored", v, exp_mem[301]);
        rd(300, v); chk("R9 busy cycle byte", v, 8'h11);
        rd(201, v); chk("R9 neighbour intact", v, 8'ha5);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule